// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host reach an internal byte-addressed register space through only two byte-wide I/O locations, using a mailbox-style handshake. One location carries data bytes. The other reads back a status byte and accepts command bytes when written. To fetch a register, the host issues the read command and then the register index. When the output-buffer-full flag rises, the host takes the value from the data location. To store a register, the host issues the write command, then the index, then the value.

Every byte the host writes sets the input-buffer-full flag. The block holds that flag for a fixed number of cycles while it takes in the byte, then clears it. The host must wait for the flag to drop before it writes the next byte. Toward the core, the block drives a simple single-cycle read/write strobe bus. A read returns its data combinationally in the same cycle.

Top module: `mbx_reg_port`

## Requirements
- R1: After reset the status byte is 0x00 and neither core strobe (`regRdEn`, `regWrEn`) is asserted. A core strobe is only ever asserted while the input-buffer-full flag is set.
- R2: Reading offset 0x04 returns the status byte. Bit 0 is output-buffer-full, bit 1 is input-buffer-full, and bit 3 is set when the most recently accepted byte arrived at offset 0x04 (a command). All other bits read 0.
- R3: A host write to offset 0x00 or 0x04 while input-buffer-full is clear is accepted. Input-buffer-full then reads 1 for exactly `CONSUME_LAT` cycles after the write edge, and then clears.
- R4: A host write made while input-buffer-full is set is dropped. It changes neither the status byte nor the sequence in progress.
- R5: Command 0x80 followed by an index byte on offset 0x00 produces one `regRdEn` pulse with `regAddr` equal to the index. This pulse falls in the last cycle of input-buffer-full. The fetched value is then presented on offset 0x00, and output-buffer-full sets on the edge that clears input-buffer-full.
- R6: Command 0x81 followed by an index byte and then a value byte produces one `regWrEn` pulse, with `regAddr` equal to the index and `regWrData` equal to the value.
- R7: A host read of offset 0x00 (with `hostRdEn`) clears output-buffer-full on the next edge. Reading the status byte leaves it unchanged.
- R8: A command byte that arrives in the middle of a sequence abandons that sequence and starts decoding afresh. Taking in any command byte also clears output-buffer-full.
- R9: A command byte other than 0x80 or 0x81, or a data byte with no command pending, causes no core access.
- R10: Offset 0x08 and every offset other than 0x00 and 0x04 read as 0x00. Writes to them are ignored and do not set input-buffer-full.
- R11: `regRdEn` and `regWrEn` are never asserted together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | HOST_AW | Host byte offset (0x00 data, 0x04 status/command, 0x08 reserved) |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host read strobe (side effect only on offset 0x00) |
| hostRdData | output | 8 | Read byte for the current `hostAddr`, combinational |
| regRdEn | output | 1 | Core register read strobe |
| regWrEn | output | 1 | Core register write strobe |
| regAddr | output | IDX_W | Core register index |
| regWrData | output | 8 | Core write value |
| regRdData | input | 8 | Core read value, valid in the `regRdEn` cycle |

## Verification
The bound checker enforces three things on every cycle. The core strobes are exclusive single-cycle pulses. A strobe only happens while input-buffer-full is set, and it frees that flag on the next edge. A fetch sets output-buffer-full, a data-port read clears it, and the reserved offset reads zero. Only the bench's scenarios can show the rest: the exact length of the input-buffer-full window, that writes made during it are dropped, that a new command abandons a half-finished write, that unknown commands and orphan data bytes cause no access, and that values written through the port read back intact.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W   = 8;
  localparam int DATA_OFS = 0;   // data port
  localparam int CTRL_OFS = 4;   // status on read, command on write
  localparam int INTC_OFS = 8;   // reserved, reads zero

  localparam logic [BYTE_W-1:0] CMD_FETCH = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_STORE = 8'h81;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RD_IDX,
    SEQ_WR_IDX,
    SEQ_WR_VAL
  } seqState_t;

  typedef struct packed {
    logic captureIn;   // latch the host byte
    logic captureCmd;  // latched byte came through the command port
    logic saveIdx;     // keep the index for a pending store
    logic loadOut;     // capture fetched value, raise OBF
    logic dropOut;     // clear OBF
    logic useIdxReg;   // core address from saved index
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int HOST_AW     = 4,
  parameter int CONSUME_LAT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [BYTE_W-1:0]    inByte,
  input  logic                 inIsCmd,
  output mbxStrobe_t           strobe,
  output logic                 ibf,
  output logic                 regRdEn,
  output logic                 regWrEn
);
  localparam int CW = $clog2(CONSUME_LAT + 1);
  localparam logic [HOST_AW-1:0] ADDR_DATA = HOST_AW'(DATA_OFS);
  localparam logic [HOST_AW-1:0] ADDR_CTRL = HOST_AW'(CTRL_OFS);

  logic hitData, hitCtrl, accept, consume;
  seqState_t seqQ, seqD;

  assign hitData = (hostAddr == ADDR_DATA);
  assign hitCtrl = (hostAddr == ADDR_CTRL);
  assign accept  = hostWrEn && !ibf && (hitData || hitCtrl);

  generate
    if (CONSUME_LAT <= 1) begin : g_direct
      assign consume = ibf;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cnt <= '0;
        end else if (accept) begin
          cnt <= CW'(CONSUME_LAT);
        end else if (ibf && cnt != CW'(1)) begin
          cnt <= cnt - CW'(1);
        end
      end
      assign consume = ibf && (cnt == CW'(1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibf <= 1'b0;
    end else if (accept) begin
      ibf <= 1'b1;
    end else if (consume) begin
      ibf <= 1'b0;
    end
  end

  always_comb begin
    seqD = seqQ;
    if (consume) begin
      if (inIsCmd) begin
        if (inByte == CMD_FETCH)      seqD = SEQ_RD_IDX;
        else if (inByte == CMD_STORE) seqD = SEQ_WR_IDX;
        else                          seqD = SEQ_IDLE;
      end else begin
        case (seqQ)
          SEQ_WR_IDX: seqD = SEQ_WR_VAL;
          default:    seqD = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqQ <= SEQ_IDLE;
    else       seqQ <= seqD;
  end

  logic dataByteIn;
  assign dataByteIn = consume && !inIsCmd;

  always_comb begin
    strobe            = '0;
    strobe.captureIn  = accept;
    strobe.captureCmd = hitCtrl;
    strobe.saveIdx    = dataByteIn && (seqQ == SEQ_WR_IDX);
    strobe.loadOut    = dataByteIn && (seqQ == SEQ_RD_IDX);
    strobe.dropOut    = (hostRdEn && hitData) || (consume && inIsCmd);
    strobe.useIdxReg  = (seqQ == SEQ_WR_VAL);
  end

  assign regRdEn = strobe.loadOut;
  assign regWrEn = dataByteIn && (seqQ == SEQ_WR_VAL);
endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int HOST_AW = 4,
  parameter int IDX_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mbxStrobe_t           strobe,
  input  logic                 ibf,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic [BYTE_W-1:0]    hostWrData,
  input  logic [BYTE_W-1:0]    regRdData,
  output logic [BYTE_W-1:0]    inByte,
  output logic                 inIsCmd,
  output logic                 obf,
  output logic [BYTE_W-1:0]    hostRdData,
  output logic [IDX_W-1:0]     regAddr,
  output logic [BYTE_W-1:0]    regWrData
);
  localparam logic [HOST_AW-1:0] ADDR_DATA = HOST_AW'(DATA_OFS);
  localparam logic [HOST_AW-1:0] ADDR_CTRL = HOST_AW'(CTRL_OFS);

  logic [IDX_W-1:0]  idxReg;
  logic [BYTE_W-1:0] outBuf;
  logic [BYTE_W-1:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inByte  <= '0;
      inIsCmd <= 1'b0;
    end else if (strobe.captureIn) begin
      inByte  <= hostWrData;
      inIsCmd <= strobe.captureCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               idxReg <= '0;
    else if (strobe.saveIdx) idxReg <= inByte[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBuf <= '0;
      obf    <= 1'b0;
    end else if (strobe.loadOut) begin
      outBuf <= regRdData;
      obf    <= 1'b1;
    end else if (strobe.dropOut) begin
      obf    <= 1'b0;
    end
  end

  always_comb begin
    statusByte         = '0;
    statusByte[ST_OBF] = obf;
    statusByte[ST_IBF] = ibf;
    statusByte[ST_CMD] = inIsCmd;
  end

  always_comb begin
    if (hostAddr == ADDR_DATA)      hostRdData = outBuf;
    else if (hostAddr == ADDR_CTRL) hostRdData = statusByte;
    else                            hostRdData = '0;
  end

  assign regAddr   = strobe.useIdxReg ? idxReg : inByte[IDX_W-1:0];
  assign regWrData = inByte;
endmodule

// File: rtl/mbx_reg_port.sv
module mbx_reg_port
  import mbx_pkg::*;
#(
  parameter int HOST_AW     = 4,
  parameter int IDX_W       = 8,
  parameter int CONSUME_LAT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic [7:0]         hostWrData,
  input  logic               hostRdEn,
  output logic [7:0]         hostRdData,
  output logic               regRdEn,
  output logic               regWrEn,
  output logic [IDX_W-1:0]   regAddr,
  output logic [7:0]         regWrData,
  input  logic [7:0]         regRdData
);
  mbxStrobe_t        strobe;
  logic              ibfW, obfW, inIsCmd;
  logic [BYTE_W-1:0] inByte;

  mbx_ctrl #(.HOST_AW(HOST_AW), .CONSUME_LAT(CONSUME_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .inByte(inByte), .inIsCmd(inIsCmd),
    .strobe(strobe), .ibf(ibfW), .regRdEn(regRdEn), .regWrEn(regWrEn)
  );

  mbx_dpath #(.HOST_AW(HOST_AW), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ibf(ibfW),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .regRdData(regRdData),
    .inByte(inByte), .inIsCmd(inIsCmd), .obf(obfW),
    .hostRdData(hostRdData), .regAddr(regAddr), .regWrData(regWrData)
  );
endmodule

// File: rtl/mbx_checks.sv
module mbx_checks
  import mbx_pkg::*;
#(
  parameter int HOST_AW = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               hostWrEn,
  input logic               hostRdEn,
  input logic [7:0]         hostRdData,
  input logic               regRdEn,
  input logic               regWrEn,
  input logic               ibf,
  input logic               obf
);
  localparam logic [HOST_AW-1:0] A_DATA = HOST_AW'(DATA_OFS);
  localparam logic [HOST_AW-1:0] A_INTC = HOST_AW'(INTC_OFS);

  a_r11_no_dual_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regWrEn));
  a_r11_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);
  a_r11_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  a_r1_strobe_needs_ibf: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn || regWrEn) |-> ibf);
  a_r3_strobe_frees_ibf: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn || regWrEn) |=> !ibf);
  a_r3_ibf_rise_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ibf) |-> $past(hostWrEn));
  a_r5_fetch_sets_obf: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> obf);
  a_r7_data_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (obf && hostRdEn && hostAddr == A_DATA && !regRdEn) |=> !obf);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == A_INTC) |-> (hostRdData == 8'h00));
endmodule

bind mbx_reg_port mbx_checks #(.HOST_AW(HOST_AW)) u_checks (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
  .hostRdEn(hostRdEn), .hostRdData(hostRdData), .regRdEn(regRdEn),
  .regWrEn(regWrEn), .ibf(ibfW), .obf(obfW)
);

// File: tb/mbx_reg_port_bench.sv
`timescale 1ns/1ps
module mbx_reg_port_bench;
  localparam int HAW = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [HAW-1:0] hostAddr = 4'h4;
  logic hostWrEn = 1'b0;
  logic hostRdEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic regRdEn, regWrEn;
  logic [7:0] regAddr, regWrData, regRdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int rdCnt = 0, wrCnt = 0;

  always #5 clk = ~clk;

  mbx_reg_port #(.HOST_AW(HAW), .IDX_W(8), .CONSUME_LAT(LAT)) u_mbx_reg_port (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // core register space
  logic [7:0] regFile [256];
  function automatic logic [7:0] initVal(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  assign regRdData = regFile[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) regFile[i] <= initVal(i);
    end else if (regWrEn) begin
      regFile[regAddr] <= regWrData;
    end
    if (rstN && regRdEn) rdCnt <= rdCnt + 1;
    if (rstN && regWrEn) wrCnt <= wrCnt + 1;
  end

  // behavioural reference model
  bit mIbf, mObf, mCmd;
  int mCnt, mSeq, mIdx;  // mSeq: 0 none, 1 await fetch index, 2 await store index, 3 await value
  logic [7:0] mBuf, mOut;

  always @(posedge clk) begin
    if (!rstN) begin
      mIbf <= 0; mObf <= 0; mCmd <= 0; mCnt <= 0; mSeq <= 0; mIdx <= 0;
      mBuf <= 0; mOut <= 0;
    end else begin
      bit take, fetchNow;
      take = mIbf && mCnt == 1;
      fetchNow = take && !mCmd && mSeq == 1;
      if (take) begin
        mIbf <= 0;
        if (mCmd) begin
          mObf <= 0;
          mSeq <= (mBuf == 8'h80) ? 1 : (mBuf == 8'h81) ? 2 : 0;
        end else if (mSeq == 1) begin
          mOut <= regFile[mBuf]; mObf <= 1; mSeq <= 0;
        end else if (mSeq == 2) begin
          mIdx <= mBuf; mSeq <= 3;
        end else begin
          mSeq <= 0;
        end
      end else if (mIbf) begin
        mCnt <= mCnt - 1;
      end
      if (hostWrEn && !mIbf && (hostAddr == 4'h0 || hostAddr == 4'h4)) begin
        mIbf <= 1; mCnt <= LAT; mBuf <= hostWrData; mCmd <= (hostAddr == 4'h4);
      end
      if (hostRdEn && hostAddr == 4'h0 && !fetchNow) mObf <= 0;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rstN && !finished) begin
      bit take, eRd, eWr;
      logic [7:0] eRead;
      take = mIbf && mCnt == 1;
      eRd = take && !mCmd && mSeq == 1;
      eWr = take && !mCmd && mSeq == 3;
      chk("R5 regRdEn", {7'd0, regRdEn}, {7'd0, eRd});
      chk("R6 regWrEn", {7'd0, regWrEn}, {7'd0, eWr});
      if (eRd) chk("R5 regAddr", regAddr, mBuf);
      if (eWr) begin
        chk("R6 regAddr", regAddr, 8'(mIdx));
        chk("R6 regWrData", regWrData, mBuf);
      end
      if (hostAddr == 4'h0)      eRead = mOut;
      else if (hostAddr == 4'h4) eRead = {4'd0, mCmd, 1'b0, mIbf, mObf};
      else                       eRead = 8'h00;
      chk("R2 hostRdData", hostRdData, eRead);
    end
  end

  task automatic waitIdle();
    @(negedge clk); hostAddr = 4'h4; #1;
    while (hostRdData[1]) begin @(negedge clk); #1; end
  endtask

  task automatic waitObf();
    @(negedge clk); hostAddr = 4'h4; #1;
    while (!hostRdData[0]) begin @(negedge clk); #1; end
  endtask

  task automatic hostWrite(logic [HAW-1:0] a, logic [7:0] d);
    waitIdle();
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0; hostAddr = 4'h4;
  endtask

  task automatic hostRead(logic [HAW-1:0] a, output logic [7:0] v);
    @(negedge clk); hostAddr = a; hostRdEn = 1'b1; #1; v = hostRdData;
    @(negedge clk); hostRdEn = 1'b0; hostAddr = 4'h4;
  endtask

  task automatic regRead(logic [7:0] idx, output logic [7:0] v);
    hostWrite(4'h4, 8'h80);
    hostWrite(4'h0, idx);
    waitObf();
    hostRead(4'h0, v);
  endtask

  task automatic regWrite(logic [7:0] idx, logic [7:0] val);
    hostWrite(4'h4, 8'h81);
    hostWrite(4'h0, idx);
    hostWrite(4'h0, val);
    waitIdle();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s;
    int n, r0, w0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 status after reset", hostRdData, 8'h00);
    chk("R1 no strobes after reset", {6'd0, regRdEn, regWrEn}, 8'h00);

    // R3: IBF window length, R2: status layout with command bit
    waitIdle();
    hostAddr = 4'h4; hostWrData = 8'h80; hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0; #1;
    chk("R2 status after command", hostRdData, 8'h0A);
    n = 0;
    while (hostRdData[1] && n < 50) begin n++; @(negedge clk); #1; end
    chk("R3 IBF cycles", 8'(n), 8'(LAT));
    hostWrite(4'h0, 8'h12);
    waitObf();
    hostRead(4'h4, s);
    chk("R2 status with OBF", s, 8'h01);
    hostRead(4'h4, s);
    chk("R7 status read keeps OBF", s, 8'h01);
    hostRead(4'h0, v);
    chk("R5 fetched value", v, initVal(8'h12));
    hostRead(4'h4, s);
    chk("R7 data read clears OBF", s, 8'h00);

    // R6: store then fetch back
    regWrite(8'h40, 8'h9C);
    regRead(8'h40, v);
    chk("R6 stored value", v, 8'h9C);

    // R8: command mid-store abandons it
    w0 = wrCnt;
    hostWrite(4'h4, 8'h81);
    hostWrite(4'h0, 8'h33);
    regRead(8'h34, v);
    chk("R8 fetch after abort", v, initVal(8'h34));
    chk("R8 no store issued", 8'(wrCnt - w0), 8'h00);
    regRead(8'h33, v);
    chk("R8 aborted index unchanged", v, initVal(8'h33));

    // R8: command clears OBF
    hostWrite(4'h4, 8'h80);
    hostWrite(4'h0, 8'h07);
    waitObf();
    hostWrite(4'h4, 8'h42);
    waitIdle(); #0;
    chk("R8 command clears OBF", hostRdData, 8'h08);

    // R9: unknown command and orphan data byte
    r0 = rdCnt; w0 = wrCnt;
    hostWrite(4'h0, 8'h10);
    hostWrite(4'h4, 8'h55);
    hostWrite(4'h0, 8'h11);
    waitIdle();
    chk("R9 no core access", 8'((rdCnt - r0) + (wrCnt - w0)), 8'h00);
    chk("R9 status idle", hostRdData, 8'h00);

    // R4: write during IBF is dropped
    waitIdle();
    hostAddr = 4'h4; hostWrData = 8'h80; hostWrEn = 1'b1;
    @(negedge clk); hostAddr = 4'h0; hostWrData = 8'h77;
    @(negedge clk); hostWrEn = 1'b0; hostAddr = 4'h4;
    waitIdle();
    chk("R4 dropped write keeps cmd bit", hostRdData, 8'h08);
    hostWrite(4'h0, 8'h05);
    waitObf();
    hostRead(4'h0, v);
    chk("R4 sequence intact", v, initVal(8'h05));

    // R10: reserved offsets
    regRead(8'h20, v);
    hostRead(4'h8, s);
    chk("R10 offset 0x08 reads zero", s, 8'h00);
    hostRead(4'hC, s);
    chk("R10 offset 0x0C reads zero", s, 8'h00);
    waitIdle();
    hostAddr = 4'h8; hostWrData = 8'hFF; hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0; hostAddr = 4'h4; #1;
    chk("R10 reserved write ignored", hostRdData, 8'h00);

    // R11: one strobe per transaction
    r0 = rdCnt; w0 = wrCnt;
    regWrite(8'hFE, 8'h3C);
    regRead(8'hFE, v);
    chk("R11 single pulses", 8'((rdCnt - r0) * 16 + (wrCnt - w0)), 8'h11);
    chk("R6 top index value", v, 8'h3C);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule